// File: doc/BRIEF.md
# Polyphase Scaler Coefficient Memory Loader

This block fills and serves the coefficient memory of a polyphase video scaler. Four filters are held: luma vertical, chroma vertical, luma horizontal and chroma horizontal. Each has 64 phases. Because the phase table is symmetric, only phases 0 through 32 are physically stored. A read of a higher phase is folded back onto a stored phase, and its tap order is reversed.

A load begins with a request that names a filter and a tap count. The loader first asks the memory power-gating controller to lift gating on the coefficient store. It then polls the controller's power status, and gives up with an error if the store does not report powered within a bounded number of attempts. Once powered, it accepts one coefficient per cycle, phase by phase and tap by tap. It packs the coefficients into even/odd pairs, each half with its own write enable, and writes them into the shadow bank. When the last phase is written it releases the gating request.

The memory is double-buffered. The scaler datapath always reads the active bank. An update request is held pending and exchanges the two banks at the next frame-start strobe, so the coefficients never change in the middle of a frame.

Top module: `cram_ram_loader`

## Requirements
- R1: After reset, coef_ready, pwr_gate_dis, ld_err, ld_done and active_bank are all 0, and rd_data is all zeros.
- R2: A load request is accepted only when the loader is idle and ld_taps lies between 2 and MAX_TAPS. An accepted request raises pwr_gate_dis in the next cycle. A request with 0, 1 or more than MAX_TAPS taps has no effect: pwr_gate_dis, coef_ready and ld_done stay 0, and the memory is not changed.
- R3: coef_ready rises only in the cycle after pwr_state has been sampled 0 while the loader is polling. It then stays high until NUM_PHASES/2+1 times ld_taps coefficients have been accepted.
- R4: If pwr_state is 1 on POLL_MAX consecutive polls (10 by default), the load is aborted. pwr_gate_dis drops after exactly POLL_MAX cycles, ld_err goes to 1, no coefficient is accepted, and the memory is unchanged. ld_err stays 1 until the next accepted load request clears it.
- R5: Coefficients arrive in phase-major, tap-minor order. Coefficient k of phase p is written into slot k of stored phase p of filter ld_filt, in the bank that is not active.
- R6: With an odd tap count, the last coefficient of each phase is written as an even half with its odd half disabled. The stored slot above it keeps its previous content.
- R7: In the cycle after the last coefficient is accepted, ld_done is 1 for exactly one cycle, and coef_ready and pwr_gate_dis are 0.
- R8: A flip_req pulse makes a bank exchange pending. active_bank toggles at the first frame_start that comes in a later cycle. A frame_start with nothing pending, or one in the same cycle as the request, does not toggle it.
- R9: rd_data is registered, with one cycle of latency from rd_filt and rd_phase. Slot k occupies bits [16k+15:16k]. For phases 0 to 32, the slots of the active bank are returned as stored.
- R10: For a phase p from 33 to 63, rd_data returns stored phase 64-p. Slot k carries stored slot n-1-k when k < n, where n is that filter's loaded tap count. Slots k >= n read as 0.
- R11: Loading never changes what the active bank returns until a flip takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 1 | Load request strobe |
| ld_filt | input | 2 | Filter to load (0 luma V, 1 chroma V, 2 luma H, 3 chroma H) |
| ld_taps | input | 3 | Tap count of the filter being loaded |
| coef_valid | input | 1 | Coefficient present on coef_data |
| coef_data | input | 16 | Coefficient value |
| coef_ready | output | 1 | Loader accepts a coefficient this cycle |
| ld_done | output | 1 | One-cycle pulse when the load completes |
| ld_err | output | 1 | Power-up poll timed out on the last load |
| pwr_gate_dis | output | 1 | Request to hold the coefficient store ungated |
| pwr_state | input | 1 | Store power status, 0 when powered |
| flip_req | input | 1 | Update-complete strobe, arms a bank exchange |
| frame_start | input | 1 | Frame boundary strobe |
| active_bank | output | 1 | Bank currently read by the datapath |
| rd_filt | input | 2 | Filter to read |
| rd_phase | input | 6 | Phase to read, 0 to 63 |
| rd_data | output | 64 | Four coefficients of the addressed phase |

## Verification
The bench aims at the phase fold. It reads phases 32, 33 and 63 of both 2-tap and 4-tap filters. A design that folded around the wrong center, or reversed the taps across the full slot width instead of the loaded tap count, would return shifted or zero-padded words. It loads a 3-tap table over an older 4-tap table, so that a loader which wrote the disabled odd half would overwrite the surviving fourth slot. It times the power poll to the exact cycle, both on success and on timeout, and issues requests with illegal tap counts. Finally, it places flip and frame strobes in the same cycle, where an eager design would exchange banks a frame early.

// File: rtl/cram_pkg.sv
`timescale 1ns/1ps
package cram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_LOAD = 2'd2
  } seq_state_e;

  // Phases above the half point are served from a stored phase.
  function automatic bit is_mirror(int p, int nph);
    return p > nph / 2;
  endfunction

  // Stored phase that backs requested phase p.
  function automatic int fold_phase(int p, int nph);
    return (p > nph / 2) ? nph - p : p;
  endfunction

  // Source slot for output slot k of a mirrored read of an n-tap filter.
  function automatic int mirror_slot(int k, int n);
    return n - 1 - k;
  endfunction

endpackage

// File: rtl/cram_write_seq.sv
`timescale 1ns/1ps
module cram_write_seq
  import cram_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 4,
  parameter int NUM_FILT   = 4,
  parameter int POLL_MAX   = 10,
  localparam int ST_PH = NUM_PHASES / 2 + 1,
  localparam int PH_W  = $clog2(NUM_PHASES),
  localparam int TAP_W = $clog2(MAX_TAPS + 1),
  localparam int SL_W  = $clog2(MAX_TAPS),
  localparam int FW    = $clog2(NUM_FILT),
  localparam int PC_W  = $clog2(POLL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_start,
  input  logic [FW-1:0]     ld_filt,
  input  logic [TAP_W-1:0]  ld_taps,
  input  logic              coef_valid,
  input  logic [COEF_W-1:0] coef_data,
  input  logic              pwr_state,
  output logic              coef_ready,
  output logic              pwr_gate_dis,
  output logic              ld_done,
  output logic              ld_err,
  output logic              in_poll,
  output logic              wr_fire,
  output logic [FW-1:0]     wr_filt,
  output logic [PH_W-1:0]   wr_phase,
  output logic [SL_W-1:0]   wr_slot,
  output logic [TAP_W-1:0]  wr_taps,
  output logic [COEF_W-1:0] wr_even,
  output logic [COEF_W-1:0] wr_odd,
  output logic              wr_odd_en
);

  seq_state_e        st_q;
  logic [FW-1:0]     filt_q;
  logic [TAP_W-1:0]  taps_q, tap_q;
  logic [PH_W-1:0]   phase_q;
  logic [COEF_W-1:0] even_q;
  logic [PC_W-1:0]   poll_q;
  logic              done_q, err_q;

  logic taps_ok, start_ok, accept, last_tap, last_phase, odd_pos;

  always_comb begin
    taps_ok    = (ld_taps >= TAP_W'(2)) && (ld_taps <= TAP_W'(MAX_TAPS));
    start_ok   = ld_start && (st_q == ST_IDLE) && taps_ok;
    accept     = coef_valid && (st_q == ST_LOAD);
    last_tap   = tap_q == (taps_q - TAP_W'(1));
    last_phase = phase_q == PH_W'(ST_PH - 1);
    odd_pos    = tap_q[0];
  end

  // Pair packing: an odd-position coefficient completes a pair; an even one
  // completes a half pair only when it closes a phase of an odd tap count.
  assign wr_fire   = accept && (odd_pos || last_tap);
  assign wr_odd_en = accept && odd_pos;
  assign wr_even   = odd_pos ? even_q : coef_data;
  assign wr_odd    = coef_data;
  assign wr_slot   = odd_pos ? SL_W'(tap_q - TAP_W'(1)) : SL_W'(tap_q);
  assign wr_phase  = phase_q;
  assign wr_filt   = filt_q;
  assign wr_taps   = taps_q;

  assign coef_ready   = st_q == ST_LOAD;
  assign pwr_gate_dis = st_q != ST_IDLE;
  assign in_poll      = st_q == ST_POLL;
  assign ld_done      = done_q;
  assign ld_err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      filt_q  <= '0;
      taps_q  <= '0;
      tap_q   <= '0;
      phase_q <= '0;
      even_q  <= '0;
      poll_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_ok) begin
            st_q    <= ST_POLL;
            filt_q  <= ld_filt;
            taps_q  <= ld_taps;
            tap_q   <= '0;
            phase_q <= '0;
            poll_q  <= '0;
            err_q   <= 1'b0;
          end
        end
        ST_POLL: begin
          if (!pwr_state) begin
            st_q <= ST_LOAD;
          end else if (poll_q == PC_W'(POLL_MAX - 1)) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b1;
          end else begin
            poll_q <= poll_q + PC_W'(1);
          end
        end
        ST_LOAD: begin
          if (accept) begin
            if (!odd_pos) even_q <= coef_data;
            if (last_tap) begin
              tap_q <= '0;
              if (last_phase) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                phase_q <= phase_q + PH_W'(1);
              end
            end else begin
              tap_q <= tap_q + TAP_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cram_bank_store.sv
`timescale 1ns/1ps
module cram_bank_store
  import cram_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 4,
  parameter int NUM_FILT   = 4,
  localparam int ST_PH = NUM_PHASES / 2 + 1,
  localparam int PH_W  = $clog2(NUM_PHASES),
  localparam int TAP_W = $clog2(MAX_TAPS + 1),
  localparam int SL_W  = $clog2(MAX_TAPS),
  localparam int FW    = $clog2(NUM_FILT),
  localparam int RD_W  = MAX_TAPS * COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [FW-1:0]     wr_filt,
  input  logic [PH_W-1:0]   wr_phase,
  input  logic [SL_W-1:0]   wr_slot,
  input  logic [TAP_W-1:0]  wr_taps,
  input  logic [COEF_W-1:0] wr_even,
  input  logic [COEF_W-1:0] wr_odd,
  input  logic              wr_odd_en,
  input  logic              flip_req,
  input  logic              frame_start,
  input  logic [FW-1:0]     rd_filt,
  input  logic [PH_W-1:0]   rd_phase,
  output logic              active_bank,
  output logic [RD_W-1:0]   rd_data
);

  logic [COEF_W-1:0] mem_q   [2][NUM_FILT][ST_PH][MAX_TAPS];
  logic [TAP_W-1:0]  ntaps_q [2][NUM_FILT];
  logic              active_q, pend_q, shadow;
  logic [RD_W-1:0]   rd_q;

  assign shadow      = ~active_q;
  assign active_bank = active_q;
  assign rd_data     = rd_q;

  // Bank exchange: armed by the update strobe, executed on a later frame edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (frame_start && pend_q) begin
      active_q <= ~active_q;
      pend_q   <= flip_req;
    end else if (flip_req) begin
      pend_q <= 1'b1;
    end
  end

  // Pair write into the shadow bank; the odd half has its own enable.
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem_q[shadow][wr_filt][wr_phase][wr_slot] <= wr_even;
      if (wr_odd_en) mem_q[shadow][wr_filt][wr_phase][wr_slot + SL_W'(1)] <= wr_odd;
      ntaps_q[shadow][wr_filt] <= wr_taps;
    end
  end

  logic             mir;
  logic [PH_W-1:0]  sp;
  logic [TAP_W-1:0] n_act;

  always_comb begin
    mir   = is_mirror(int'(rd_phase), NUM_PHASES);
    sp    = PH_W'(fold_phase(int'(rd_phase), NUM_PHASES));
    n_act = ntaps_q[active_q][rd_filt];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      for (int k = 0; k < MAX_TAPS; k++) begin
        if (!mir)
          rd_q[k*COEF_W +: COEF_W] <= mem_q[active_q][rd_filt][sp][SL_W'(k)];
        else if (k < int'(n_act))
          rd_q[k*COEF_W +: COEF_W] <=
            mem_q[active_q][rd_filt][sp][SL_W'(mirror_slot(k, int'(n_act)))];
        else
          rd_q[k*COEF_W +: COEF_W] <= '0;
      end
    end
  end

endmodule

// File: rtl/cram_ram_loader.sv
`timescale 1ns/1ps
module cram_ram_loader
  import cram_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 4,
  parameter int NUM_FILT   = 4,
  parameter int POLL_MAX   = 10,
  localparam int PH_W  = $clog2(NUM_PHASES),
  localparam int TAP_W = $clog2(MAX_TAPS + 1),
  localparam int SL_W  = $clog2(MAX_TAPS),
  localparam int FW    = $clog2(NUM_FILT),
  localparam int RD_W  = MAX_TAPS * COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_start,
  input  logic [FW-1:0]     ld_filt,
  input  logic [TAP_W-1:0]  ld_taps,
  input  logic              coef_valid,
  input  logic [COEF_W-1:0] coef_data,
  output logic              coef_ready,
  output logic              ld_done,
  output logic              ld_err,
  output logic              pwr_gate_dis,
  input  logic              pwr_state,
  input  logic              flip_req,
  input  logic              frame_start,
  output logic              active_bank,
  input  logic [FW-1:0]     rd_filt,
  input  logic [PH_W-1:0]   rd_phase,
  output logic [RD_W-1:0]   rd_data
);

  // Internal events between sequencer and store, named for the checker.
  logic              in_poll;
  logic              wr_fire;
  logic [FW-1:0]     wr_filt;
  logic [PH_W-1:0]   wr_phase;
  logic [SL_W-1:0]   wr_slot;
  logic [TAP_W-1:0]  wr_taps;
  logic [COEF_W-1:0] wr_even, wr_odd;
  logic              wr_odd_en;

  cram_write_seq #(
    .COEF_W(COEF_W), .NUM_PHASES(NUM_PHASES), .MAX_TAPS(MAX_TAPS),
    .NUM_FILT(NUM_FILT), .POLL_MAX(POLL_MAX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ld_start(ld_start), .ld_filt(ld_filt), .ld_taps(ld_taps),
    .coef_valid(coef_valid), .coef_data(coef_data), .pwr_state(pwr_state),
    .coef_ready(coef_ready), .pwr_gate_dis(pwr_gate_dis),
    .ld_done(ld_done), .ld_err(ld_err), .in_poll(in_poll),
    .wr_fire(wr_fire), .wr_filt(wr_filt), .wr_phase(wr_phase),
    .wr_slot(wr_slot), .wr_taps(wr_taps), .wr_even(wr_even),
    .wr_odd(wr_odd), .wr_odd_en(wr_odd_en)
  );

  cram_bank_store #(
    .COEF_W(COEF_W), .NUM_PHASES(NUM_PHASES), .MAX_TAPS(MAX_TAPS),
    .NUM_FILT(NUM_FILT)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_filt(wr_filt), .wr_phase(wr_phase),
    .wr_slot(wr_slot), .wr_taps(wr_taps), .wr_even(wr_even),
    .wr_odd(wr_odd), .wr_odd_en(wr_odd_en),
    .flip_req(flip_req), .frame_start(frame_start),
    .rd_filt(rd_filt), .rd_phase(rd_phase),
    .active_bank(active_bank), .rd_data(rd_data)
  );

endmodule

// File: rtl/cram_ram_loader_chk.sv
`timescale 1ns/1ps
module cram_ram_loader_chk #(
  parameter int POLL_MAX = 10,
  parameter int TAP_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             coef_ready,
  input logic             coef_valid,
  input logic             pwr_gate_dis,
  input logic             pwr_state,
  input logic             ld_err,
  input logic             ld_done,
  input logic             active_bank,
  input logic             frame_start,
  input logic             in_poll,
  input logic             wr_fire,
  input logic             wr_odd_en,
  input logic [TAP_W-1:0] wr_taps
);

  localparam int CW = $clog2(POLL_MAX + 2);
  logic [CW-1:0] poll_len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) poll_len_q <= '0;
    else if (in_poll) poll_len_q <= poll_len_q + CW'(1);
    else poll_len_q <= '0;
  end

  AST_READY_UNDER_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    coef_ready |-> pwr_gate_dis);  // R3
  AST_READY_AFTER_ZERO_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coef_ready) |-> ($past(in_poll) && !$past(pwr_state)));  // R3
  AST_POLL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    in_poll |-> (poll_len_q < CW'(POLL_MAX)));  // R4
  AST_ERR_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> !coef_ready);  // R4
  AST_WRITE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (coef_ready && coef_valid));  // R5
  AST_HALF_PAIR_ODD_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_odd_en) |-> wr_taps[0]);  // R6
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> (!pwr_gate_dis && !coef_ready));  // R7
  AST_FLIP_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_bank) |-> $past(frame_start));  // R8

endmodule

bind cram_ram_loader cram_ram_loader_chk #(.POLL_MAX(POLL_MAX), .TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .coef_ready(coef_ready), .coef_valid(coef_valid),
  .pwr_gate_dis(pwr_gate_dis), .pwr_state(pwr_state), .ld_err(ld_err),
  .ld_done(ld_done), .active_bank(active_bank), .frame_start(frame_start),
  .in_poll(in_poll), .wr_fire(wr_fire), .wr_odd_en(wr_odd_en), .wr_taps(wr_taps)
);

// File: tb/cram_ram_loader_test.sv
`timescale 1ns/1ps
module cram_ram_loader_test;

  localparam int NP = 64, MT = 4, HALF = NP / 2, PM = 10;

  logic        clk = 1'b0;
  logic        rst_n, ld_start, coef_valid, pwr_state, flip_req, frame_start;
  logic [1:0]  ld_filt, rd_filt;
  logic [2:0]  ld_taps;
  logic [15:0] coef_data;
  logic [5:0]  rd_phase;
  logic        coef_ready, ld_done, ld_err, pwr_gate_dis, active_bank;
  logic [63:0] rd_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cram_ram_loader uut (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_filt(ld_filt),
    .ld_taps(ld_taps), .coef_valid(coef_valid), .coef_data(coef_data),
    .coef_ready(coef_ready), .ld_done(ld_done), .ld_err(ld_err),
    .pwr_gate_dis(pwr_gate_dis), .pwr_state(pwr_state), .flip_req(flip_req),
    .frame_start(frame_start), .active_bank(active_bank), .rd_filt(rd_filt),
    .rd_phase(rd_phase), .rd_data(rd_data)
  );

  // {filter, taps, seed, power-up delay}; loaded in the order V luma, V chroma, H luma, H chroma
  localparam logic [16:0] VEC [4] = '{
    {2'd0, 3'd4, 8'h11, 4'd0},
    {2'd1, 3'd2, 8'h22, 4'd2},
    {2'd2, 3'd4, 8'h33, 4'd5},
    {2'd3, 3'd2, 8'h44, 4'd1}
  };

  function automatic logic [15:0] cv(int seed, int p, int k);
    return 16'(((seed & 255) << 8) | ((p & 63) << 2) | (k & 3));
  endfunction

  // Expected slot k of a read of phase ph for a filter loaded with `seed`, `taps`
  function automatic logic [15:0] exp_word(int seed, int taps, int ph, int k);
    if (ph <= HALF) return cv(seed, ph, k);
    if (k < taps) return cv(seed, NP - ph, taps - 1 - k);
    return 16'h0;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input int filt, input int taps, input int seed, input int pdly);
    @(negedge clk);
    ld_start = 1'b1; ld_filt = 2'(filt); ld_taps = 3'(taps);
    pwr_state = (pdly > 0);
    @(negedge clk);
    ld_start = 1'b0;
    check(64'(pwr_gate_dis), 64'd1, "R2 gate request after start");
    check(64'(coef_ready), 64'd0, "R3 not ready while polling");
    repeat (pdly) @(negedge clk);
    pwr_state = 1'b0;
    @(negedge clk);
    check(64'(coef_ready), 64'd1, "R3 ready one cycle after zero poll");
    for (int p = 0; p <= HALF; p++) begin
      for (int k = 0; k < taps; k++) begin
        coef_valid = 1'b1;
        coef_data  = cv(seed, p, k);
        @(negedge clk);
      end
    end
    coef_valid = 1'b0;
    check(64'(ld_done), 64'd1, "R7 done pulse");
    check(64'(coef_ready), 64'd0, "R7 ready dropped");
    check(64'(pwr_gate_dis), 64'd0, "R7 gate released");
    @(negedge clk);
    check(64'(ld_done), 64'd0, "R7 done one cycle");
  endtask

  task automatic rd(input int filt, input int ph, output logic [63:0] d);
    rd_filt = 2'(filt); rd_phase = 6'(ph);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic chk_read(input int filt, input int ph, input int seed, input int taps,
                          input string tag);
    logic [63:0] d;
    int n;
    rd(filt, ph, d);
    n = (ph <= HALF) ? taps : MT;
    for (int k = 0; k < n; k++)
      check(64'(d[k*16 +: 16]), 64'(exp_word(seed, taps, ph, k)), tag);
  endtask

  task automatic do_flip(input logic expect_bank);
    @(negedge clk); flip_req = 1'b1;
    @(negedge clk); flip_req = 1'b0; frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    check(64'(active_bank), 64'(expect_bank), "R8 flip at frame start");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    int gcnt;
    bit saw_ready;
    rst_n = 0; ld_start = 0; ld_filt = 0; ld_taps = 0; coef_valid = 0; coef_data = 0;
    pwr_state = 0; flip_req = 0; frame_start = 0; rd_filt = 0; rd_phase = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(64'(coef_ready), 64'd0, "R1 ready");
    check(64'(pwr_gate_dis), 64'd0, "R1 gate");
    check(64'(ld_err), 64'd0, "R1 err");
    check(64'(ld_done), 64'd0, "R1 done");
    check(64'(active_bank), 64'd0, "R1 bank");
    check(rd_data, 64'd0, "R1 read data");

    // Vector table: four filters into the shadow bank, then one flip
    for (int i = 0; i < 4; i++) begin
      do_load(int'(VEC[i][16:15]), int'(VEC[i][14:12]), int'(VEC[i][11:4]), int'(VEC[i][3:0]));
    end
    do_flip(1'b1);
    for (int i = 0; i < 4; i++) begin
      int f, t, s;
      f = int'(VEC[i][16:15]); t = int'(VEC[i][14:12]); s = int'(VEC[i][11:4]);
      chk_read(f, 0, s, t, "R5 R9 raw phase 0");
      chk_read(f, 7, s, t, "R5 R9 raw phase 7");
      chk_read(f, 32, s, t, "R9 raw phase 32");
      chk_read(f, 33, s, t, "R10 mirror phase 33");
      chk_read(f, 50, s, t, "R10 mirror phase 50");
      chk_read(f, 63, s, t, "R10 mirror phase 63");
    end

    // R8: frame start with nothing pending does not flip
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    check(64'(active_bank), 64'd1, "R8 no flip without request");

    // R11: load into shadow bank 0; active bank 1 unchanged
    do_load(0, 4, 8'h55, 1);
    chk_read(0, 3, 8'h11, 4, "R11 active bank unchanged by load");

    // R8: request and frame start in the same cycle do not flip yet
    @(negedge clk); flip_req = 1'b1; frame_start = 1'b1;
    @(negedge clk); flip_req = 1'b0; frame_start = 1'b0;
    check(64'(active_bank), 64'd1, "R8 same-cycle request waits");
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    check(64'(active_bank), 64'd0, "R8 flip on later frame start");
    chk_read(0, 3, 8'h55, 4, "R5 new bank contents");

    // R6: 3-tap load over the older 4-tap table in bank 1
    do_load(0, 3, 8'h77, 3);
    do_flip(1'b1);
    rd(0, 4, d);
    for (int k = 0; k < 3; k++)
      check(64'(d[k*16 +: 16]), 64'(cv(8'h77, 4, k)), "R6 written slots");
    check(64'(d[48 +: 16]), 64'(cv(8'h11, 4, 3)), "R6 odd half left intact");
    chk_read(0, 60, 8'h77, 3, "R10 mirror of 3-tap filter");

    // R2: illegal tap counts are ignored
    @(negedge clk); ld_start = 1'b1; ld_filt = 2'd2; ld_taps = 3'd1;
    @(negedge clk); ld_taps = 3'd5;
    @(negedge clk); ld_start = 1'b0;
    check(64'(pwr_gate_dis), 64'd0, "R2 ignored request gate");
    check(64'(coef_ready), 64'd0, "R2 ignored request ready");
    @(negedge clk);
    check(64'(ld_done), 64'd0, "R2 ignored request done");
    chk_read(2, 10, 8'h33, 4, "R2 memory untouched");

    // R4: power never comes up
    @(negedge clk); ld_start = 1'b1; ld_filt = 2'd1; ld_taps = 3'd2; pwr_state = 1'b1;
    @(negedge clk); ld_start = 1'b0;
    gcnt = 0; saw_ready = 0;
    for (int c = 0; c < 30; c++) begin
      if (pwr_gate_dis) gcnt++;
      if (coef_ready) saw_ready = 1;
      coef_valid = 1'b1; coef_data = 16'hDEAD;
      @(negedge clk);
    end
    coef_valid = 1'b0;
    check(64'(gcnt), 64'(PM), "R4 gate held for poll limit");
    check(64'(saw_ready), 64'd0, "R4 nothing accepted");
    check(64'(ld_err), 64'd1, "R4 error raised");
    chk_read(1, 5, 8'h22, 2, "R4 memory untouched");
    pwr_state = 1'b0;
    do_load(1, 2, 8'h88, 0);
    check(64'(ld_err), 64'd0, "R4 error cleared by accepted load");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule